// File: doc/BRIEF.md
# Pipelined Burst SRAM Core

This block is a small synchronous memory that behaves like a pipelined burst static RAM. Address, control and write data are captured at the rising clock edge, and read data leaves a register one cycle after its address is taken. The memory is split into four 9-bit byte lanes. Each lane holds eight data bits and one parity bit, and each lane can be written on its own. A burst starts on either of two start strobes. Once started, it can walk through the four words of an aligned group in linear or interleaved order, or it can hold on the current word.

The data bus is modelled as a three-state pair: a read-data vector and a drive-enable flag. The drive enable depends on chip selection, on a pipelined read being ready, on an asynchronous output enable, on any write in progress and on a sleep input. While sleep is high the clock is gated inside the block, so no state changes and the stored words are kept. The memory depth is a parameter and is kept small.

Top module: `psb_sram`

## Requirements
- R1: The part counts as selected only when `ce_n`=0, `cs0`=1 and `cs1_n`=0. A deselect cycle is one of these:
  - `ctrl_strobe_n`=0 while not selected;
  - `proc_strobe_n`=0 with `ce_n`=0 while not selected.

  A deselect cycle turns `dq_oe` off after its edge and ends the burst. Later cycles with no strobe then neither read nor write.
- R2: `proc_strobe_n` is gated by `ce_n`. With `ce_n`=1 and `ctrl_strobe_n`=1, a low `proc_strobe_n` is treated as a continue or suspend cycle.
- R3: A start loads `addr_i` as the burst base. A start from `proc_strobe_n` is always a read, whatever `gw_n`, `bwe_n` and `bw_n` are. A start from `ctrl_strobe_n` (with `proc_strobe_n` high) reads or writes according to those inputs.
- R4: `gw_n`=0 on a write-capable cycle writes all four lanes from `dq_in`. This holds whatever `bwe_n` and `bw_n` are.
- R5: Lane i covers `dq_in[8i+7:8i]` together with parity bit `dq_in[32+i]`.
  - With `gw_n`=1 and `bwe_n`=0, every `bw_n[i]`=0 writes lane i, and several lanes may be written at once.
  - With `gw_n`=1 and `bwe_n`=1, nothing is written.
- R6: A read cycle registers the addressed word. From the next edge, `dq_out` shows that word and `dq_oe` can be high, until the following edge.
- R7: `dq_oe` is low during any cycle whose inputs make it a write, and after the edge of a write.
- R8: `oe_n`=1 forces `dq_oe` low at once, without waiting for a clock edge.
- R9: A cycle with no strobe and `adv_n`=0, during an active burst, steps a 2-bit count n and uses word offset f(base,n) within the aligned group of four. f is (base+n) mod 4 when `burst_xor`=0 and base XOR n when `burst_xor`=1. The fifth access wraps back to the base.
- R10: A cycle with no strobe and `adv_n`=1, during an active burst, reuses the current address. A write made then lands on that same word.
- R11: While `sleep`=1, no edge changes any state, the stored data is kept, and `dq_oe` is low.
- R12: After reset `dq_oe` is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr_i | input | ADDR_W | Word address, taken on a start |
| ce_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| cs0 | input | 1 | Chip select, active high |
| cs1_n | input | 1 | Chip select, active low |
| proc_strobe_n | input | 1 | Read-only start strobe, active low |
| ctrl_strobe_n | input | 1 | Start strobe that may write, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Write-all-lanes, active low |
| bwe_n | input | 1 | Lane-write gate, active low |
| bw_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_xor | input | 1 | Burst order: 1 interleaved, 0 linear; static during a burst |
| sleep | input | 1 | Clock gate and bus off, active high |
| dq_in | input | LANES*9 | Write data |
| dq_out | output | LANES*9 | Registered read data |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The assertions assume every control input is 0 or 1 at each sampled edge after reset. They also assume `burst_xor` does not change while a burst is active, because the sequencer checks compare the count across edges. The bench drives inputs only at falling edges. It changes the burst order only after a deselect cycle, and it keeps the order fixed during the randomized phase. It writes every word once before any read, so that each compared read returns known data.

// File: rtl/psb_pkg.sv
package psb_pkg;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_DESEL,
    OP_START_P,
    OP_START_C,
    OP_CONT,
    OP_SUSP
  } psb_op_e;

  // Word offset inside the aligned group of four for burst count n.
  function automatic logic [1:0] burst_off(input logic [1:0] base,
                                           input logic [1:0] n,
                                           input logic       use_xor);
    return use_xor ? (base ^ n) : (base + n);
  endfunction

endpackage

// File: rtl/psb_cmd_decode.sv
module psb_cmd_decode
  import psb_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             ce_n,
  input  logic             cs0,
  input  logic             cs1_n,
  input  logic             proc_strobe_n,
  input  logic             ctrl_strobe_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bw_n,
  input  logic             active,
  input  logic             sleep,
  output psb_op_e          op,
  output logic [LANES-1:0] wr_lanes
);

  logic selected;

  always_comb begin
    selected = !ce_n && cs0 && !cs1_n;
    op = OP_IDLE;
    if (!sleep) begin
      if (!proc_strobe_n && !ce_n)  op = selected ? OP_START_P : OP_DESEL;
      else if (!ctrl_strobe_n)      op = selected ? OP_START_C : OP_DESEL;
      else if (active)              op = adv_n ? OP_SUSP : OP_CONT;
    end
  end

  always_comb begin
    wr_lanes = '0;
    if (op inside {OP_START_C, OP_CONT, OP_SUSP}) begin
      if (!gw_n)       wr_lanes = '1;
      else if (!bwe_n) wr_lanes = ~bw_n;
    end
  end

endmodule

// File: rtl/psb_burst_seq.sv
module psb_burst_seq
  import psb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              hold,
  input  logic              use_xor,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      base_q;
  logic [1:0]      cnt_q;
  logic [1:0]      cnt_use;

  assign cnt_use  = step ? cnt_q + 2'd1 : cnt_q;
  assign cur_addr = load ? addr_i : {hi_q, burst_off(base_q, cnt_use, use_xor)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      hi_q   <= addr_i[ADDR_W-1:2];
      base_q <= addr_i[1:0];
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_q + 2'd1;
    end
  end

  // R9
  step_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (cnt_q == $past(cnt_q) + 2'd1));

  // R10
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(cnt_q) && $stable(hi_q) && $stable(base_q)));

endmodule

// File: rtl/psb_lane_array.sv
module psb_lane_array #(
  parameter int LANES  = 4,
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [LANES-1:0]   we_lanes,
  input  logic               re,
  input  logic [LANES*9-1:0] wdata,
  output logic [LANES*9-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PBASE = LANES * 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [8:0] mem [DEPTH];
    logic [8:0] wr_lane;
    logic [8:0] rd_lane;

    assign wr_lane = {wdata[PBASE+i], wdata[8*i +: 8]};

    always_ff @(posedge clk) begin
      if (we_lanes[i]) mem[addr] <= wr_lane;
      if (re)          rd_lane   <= mem[addr];
    end

    assign rdata[8*i +: 8]  = rd_lane[7:0];
    assign rdata[PBASE + i] = rd_lane[8];
  end

endmodule

// File: rtl/psb_sram.sv
module psb_sram
  import psb_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               ce_n,
  input  logic               cs0,
  input  logic               cs1_n,
  input  logic               proc_strobe_n,
  input  logic               ctrl_strobe_n,
  input  logic               adv_n,
  input  logic               gw_n,
  input  logic               bwe_n,
  input  logic [LANES-1:0]   bw_n,
  input  logic               oe_n,
  input  logic               burst_xor,
  input  logic               sleep,
  input  logic [LANES*9-1:0] dq_in,
  output logic [LANES*9-1:0] dq_out,
  output logic               dq_oe
);

  psb_op_e           op;
  logic [LANES-1:0]  wr_lanes;
  logic [ADDR_W-1:0] cur_addr;
  logic              active_q;
  logic              rd_valid_q;
  logic              start_evt;
  logic              wr_evt;
  logic              rd_evt;

  psb_cmd_decode #(.LANES(LANES)) u_dec (
    .ce_n(ce_n), .cs0(cs0), .cs1_n(cs1_n),
    .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
    .active(active_q), .sleep(sleep),
    .op(op), .wr_lanes(wr_lanes)
  );

  assign start_evt = (op == OP_START_P) || (op == OP_START_C);
  assign wr_evt    = |wr_lanes;
  assign rd_evt    = (start_evt || op == OP_CONT || op == OP_SUSP) && !wr_evt;

  psb_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .load(start_evt), .step(op == OP_CONT), .hold(op == OP_SUSP),
    .use_xor(burst_xor), .addr_i(addr_i), .cur_addr(cur_addr)
  );

  psb_lane_array #(.LANES(LANES), .ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .addr(cur_addr), .we_lanes(wr_lanes), .re(rd_evt),
    .wdata(dq_in), .rdata(dq_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      rd_valid_q <= 1'b0;
    end else if (!sleep) begin
      rd_valid_q <= rd_evt;
      if (start_evt)          active_q <= 1'b1;
      else if (op == OP_DESEL) active_q <= 1'b0;
    end
  end

  assign dq_oe = rd_valid_q && !oe_n && !sleep && !wr_evt;

  // R1
  desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_DESEL) |=> (!dq_oe && !active_q));

  // R3
  proc_start_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_START_P) |-> (wr_lanes == '0));

  // R6
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> rd_valid_q);

  // R7
  wr_bus_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !rd_valid_q);

  // R11
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> ($stable(rd_valid_q) && $stable(active_q)));

endmodule

// File: tb/psb_sram_tb.sv
module psb_sram_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 4;
  localparam int ADDR_W = 6;
  localparam int DW     = LANES * 9;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic ce_n = 1'b0, cs0 = 1'b1, cs1_n = 1'b0;
  logic proc_strobe_n = 1'b1, ctrl_strobe_n = 1'b1, adv_n = 1'b1;
  logic gw_n = 1'b1, bwe_n = 1'b1;
  logic [LANES-1:0] bw_n = '1;
  logic oe_n = 1'b0, burst_xor = 1'b0, sleep = 1'b0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  psb_sram #(.LANES(LANES), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .ce_n(ce_n), .cs0(cs0),
    .cs1_n(cs1_n), .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
    .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
    .burst_xor(burst_xor), .sleep(sleep), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe)
  );

  // behavioural reference state
  logic [DW-1:0] m_mem [DEPTH];
  bit            m_active = 0, m_valid = 0;
  logic [DW-1:0] m_rdata = '0;
  int            m_group = 0, m_base = 0, m_cnt = 0;

  int checks = 0, errors = 0;
  string cur_req = "R12";

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    logic [31:0] d;
    d = 32'(a) * 32'h0101_0101 ^ (32'h5A3C_96E1 + 32'(salt));
    return {4'(a + salt), d};
  endfunction

  // one clock: check outputs for the held inputs, then advance the model
  task automatic step();
    int kind;            // 0 none, 1 deselect, 2 read start, 3 ctrl start, 4 advance, 5 hold
    bit sel;
    int lanes, used, n, off;
    bit exp_oe;
    sel  = !ce_n && cs0 && !cs1_n;
    kind = 0;
    if (!sleep) begin
      if (proc_strobe_n == 0 && ce_n == 0) kind = sel ? 2 : 1;
      else if (ctrl_strobe_n == 0)         kind = sel ? 3 : 1;
      else if (m_active)                   kind = adv_n ? 5 : 4;
    end
    lanes = 0;
    if (kind >= 3) begin
      if (!gw_n)       lanes = 15;
      else if (!bwe_n) lanes = int'(~bw_n) & 15;
    end
    if (kind == 2 || kind == 3) used = int'(addr_i);
    else begin
      n   = (kind == 4) ? (m_cnt + 1) % 4 : m_cnt;
      off = burst_xor ? (m_base ^ n) : (m_base + n) % 4;
      used = m_group * 4 + off;
    end
    exp_oe = m_valid && !oe_n && !sleep && lanes == 0;
    #1;
    checks++;
    if (dq_oe !== exp_oe) begin
      errors++;
      $display("FAIL %s bus enable: actual %b expected %b at %0t", cur_req, dq_oe, exp_oe, $time);
    end
    if (exp_oe) begin
      checks++;
      if (dq_out !== m_rdata) begin
        errors++;
        $display("FAIL %s read data: actual %h expected %h at %0t", cur_req, dq_out, m_rdata, $time);
      end
    end
    @(posedge clk);
    if (kind != 0 || !sleep) begin
      if (!sleep) m_valid = (kind >= 2) && lanes == 0;
      if (kind == 1) m_active = 0;
      if (kind == 2 || kind == 3) begin
        m_active = 1; m_group = used / 4; m_base = used % 4; m_cnt = 0;
      end
      if (kind == 4) m_cnt = (m_cnt + 1) % 4;
      if (m_valid) m_rdata = m_mem[used];
      for (int i = 0; i < LANES; i++) begin
        if (lanes[i]) begin
          m_mem[used][8*i +: 8]   = dq_in[8*i +: 8];
          m_mem[used][LANES*8 + i] = dq_in[LANES*8 + i];
        end
      end
    end
    @(negedge clk);
  endtask

  task automatic cyc(input bit pn, input bit cn, input bit an, input bit gwn,
                     input bit bwen, input logic [3:0] bwn, input int a,
                     input logic [DW-1:0] d);
    proc_strobe_n = pn; ctrl_strobe_n = cn; adv_n = an;
    gw_n = gwn; bwe_n = bwen; bw_n = bwn; addr_i = ADDR_W'(a); dq_in = d;
    step();
  endtask

  task automatic idle(); cyc(1, 1, 1, 1, 1, 4'hF, 0, '0); endtask

  task automatic deselect();
    ce_n = 1'b1; cyc(1, 0, 1, 1, 1, 4'hF, 0, '0); ce_n = 1'b0;
  endtask

  task automatic read_burst(input int a, input int beats);
    cyc(0, 1, 1, 0, 0, 4'h0, a, '1);          // write inputs ignored on this start
    for (int k = 0; k < beats; k++) cyc(1, 1, 0, 1, 1, 4'hF, 0, '0);
    idle(); idle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    checks++;
    if (dq_oe !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset bus enable: actual %b expected 0", dq_oe);
    end
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R12";
    idle();

    // R3 R9: ctrl-started write bursts fill the whole array, linear order
    cur_req = "R3";
    for (int b = 0; b < DEPTH / 4; b++) begin
      cyc(1, 0, 1, 0, 1, 4'hF, b * 4, pat(b * 4, 0));
      for (int k = 1; k < 4; k++) cyc(1, 1, 0, 0, 1, 4'hF, 0, pat(b * 4 + k, 0));
    end
    idle();

    // R6 R3: read-only start with write inputs active, then linear advance
    cur_req = "R6";
    read_burst(8, 3);

    // R2: processor strobe with chip enable high acts as advance
    cur_req = "R2";
    cyc(0, 1, 1, 1, 1, 4'hF, 12, '0);
    ce_n = 1'b1;
    cyc(0, 1, 0, 1, 1, 4'hF, 40, '0);
    cyc(0, 1, 0, 1, 1, 4'hF, 40, '0);
    ce_n = 1'b0;
    idle();

    // R9: interleaved order with wrap, then linear from the same base
    cur_req = "R9";
    deselect();
    burst_xor = 1'b1;
    read_burst(6, 4);
    read_burst(17, 4);
    deselect();
    burst_xor = 1'b0;
    read_burst(6, 4);
    read_burst(19, 4);

    // R4: global write overrides lane inputs
    cur_req = "R4";
    cyc(1, 0, 1, 0, 0, 4'hF, 20, 36'hF_1234_5678);
    idle();
    read_burst(20, 0);

    // R5: lane writes and blocked lane writes
    cur_req = "R5";
    cyc(1, 0, 1, 1, 0, 4'b1010, 21, 36'hA_AABB_CCDD);
    cyc(1, 1, 1, 1, 1, 4'b0000, 0, 36'h5_0000_0000);
    cyc(1, 1, 0, 1, 0, 4'b0000, 0, 36'h6_1111_2222);
    idle();
    read_burst(21, 1);

    // R10: suspend keeps the address for a write
    cur_req = "R10";
    cyc(1, 0, 1, 0, 1, 4'hF, 30, 36'h1_0000_0001);
    cyc(1, 1, 1, 0, 1, 4'hF, 0, 36'h2_0000_0002);
    cyc(1, 1, 0, 0, 1, 4'hF, 0, 36'h3_0000_0003);
    idle();
    read_burst(30, 2);

    // R7: write while read data is pending
    cur_req = "R7";
    cyc(0, 1, 1, 1, 1, 4'hF, 33, '0);
    cyc(1, 1, 0, 1, 1, 4'hF, 0, '0);
    cyc(1, 1, 0, 0, 1, 4'hF, 0, 36'h7_7777_7777);
    cyc(1, 1, 0, 1, 1, 4'hF, 0, '0);
    idle();

    // R8: output enable high hides a read, low shows it
    cur_req = "R8";
    oe_n = 1'b1;
    cyc(0, 1, 1, 1, 1, 4'hF, 44, '0);
    cyc(1, 1, 0, 1, 1, 4'hF, 0, '0);
    oe_n = 1'b0;
    step();
    oe_n = 1'b1;
    step();
    oe_n = 1'b0;
    idle();

    // R1: each deselect form ends the burst
    cur_req = "R1";
    cyc(0, 1, 1, 1, 1, 4'hF, 48, '0);
    cs0 = 1'b0; cyc(0, 1, 1, 1, 1, 4'hF, 0, '0); cs0 = 1'b1;
    cyc(1, 1, 0, 0, 1, 4'hF, 0, 36'hB_BBBB_BBBB);
    cyc(0, 1, 1, 1, 1, 4'hF, 48, '0);
    cs1_n = 1'b1; cyc(1, 0, 1, 1, 1, 4'hF, 0, '0); cs1_n = 1'b0;
    idle();
    cyc(0, 1, 1, 1, 1, 4'hF, 49, '0);
    deselect();
    cyc(1, 1, 0, 1, 1, 4'hF, 0, '0);
    read_burst(48, 1);

    // R11: sleep blocks writes, freezes state, turns bus off
    cur_req = "R11";
    cyc(0, 1, 1, 1, 1, 4'hF, 40, '0);
    sleep = 1'b1;
    cyc(1, 0, 1, 0, 1, 4'hF, 40, 36'hC_CCCC_CCCC);
    cyc(1, 1, 0, 0, 1, 4'hF, 0, 36'hD_DDDD_DDDD);
    cyc(1, 1, 0, 1, 1, 4'hF, 0, '0);
    sleep = 1'b0;
    step();
    cyc(1, 1, 0, 1, 1, 4'hF, 0, '0);
    read_burst(40, 1);

    // R6: mixed traffic against the reference
    cur_req = "R6";
    for (int t = 0; t < 600; t++) begin
      logic [3:0] r;
      r = 4'($urandom_range(0, 15));
      ce_n  = ($urandom_range(0, 9) == 0);
      cs0   = ($urandom_range(0, 9) != 0);
      cs1_n = ($urandom_range(0, 9) == 0);
      oe_n  = ($urandom_range(0, 7) == 0);
      sleep = ($urandom_range(0, 15) == 0);
      cyc(r[0] | r[1], ~(r[0] & r[1]), r[2], $urandom_range(0, 3) != 0,
          r[3], 4'($urandom_range(0, 15)), int'($urandom_range(0, DEPTH - 1)),
          {4'($urandom), 32'($urandom)});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule